// File: doc/BRIEF.md
# Selectable Training Vector Post-Processor

This block takes result vectors from a matrix unit and finishes them lane by lane through a fixed four-stage pipeline. Stage 1 adds a per-lane bias. Stage 2 applies a leaky rectifier. Stage 3 forms the gradient of a mean-squared-error loss against a target vector. Stage 4 multiplies an incoming gradient by the derivative of the leaky rectifier, using activations saved during the forward pass. A 4-bit pathway code sent with each beat turns stages on or off. One datapath therefore serves the forward pass (bias and activation) and the backward pass (loss gradient and derivative).

All numbers are signed 16-bit fixed point with 8 fractional bits, so 0x0100 is 1.0. Input and output are valid/ready streams. A beat is taken on a clock edge where `in_valid` and `in_ready` are both high, and it is delivered on an edge where `out_valid` and `out_ready` are both high. When the output is held off, the whole pipeline freezes. `in_ready` then drops in the same cycle, and no beat is lost or reordered. The bias, target, activation, pathway, leak and scale inputs are sampled together with the data beat.

Top module: `vec_postproc`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. A reset applied while beats are in flight discards them.
- R2: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_valid` and `out_data` hold. With the output stalled from an empty state, exactly 4 beats are accepted before `in_ready` falls.
- R3: When `out_ready` stays high, a beat taken at edge k appears on `out_valid`/`out_data` right after edge k+3, for every pathway code. One beat per cycle is sustained.
- R4: Pathway bit 0 enables bias addition followed by the leaky rectifier. Code 0001 therefore is the forward path.
- R5: Bias addition is a 16-bit two's-complement add that wraps on overflow.
- R6: The leaky rectifier passes x unchanged when x >= 0. Otherwise it outputs (x * leak) >>> 8, keeping the low 16 bits, which rounds toward minus infinity.
- R7: Pathway bit 1 enables the loss stage, which outputs ((x - target) * scale) >>> 8. The difference wraps to 16 bits. The scale is the precomputed 2/N constant.
- R8: Pathway bit 2 enables the derivative stage. It outputs x when the stored activation is greater than 0, and (x * leak) >>> 8 otherwise, including when the activation is exactly 0.
- R9: When several bits are set, the enabled stages apply in the order bias, rectifier, loss, derivative.
- R10: Pathway bit 3 has no effect. Code 0000 delivers the input vector unchanged.
- R11: Every beat is processed with its own pathway, leak, scale and operand values, even when neighbouring beats in flight use different ones.
- R12: Under any pattern of `in_valid` and `out_ready`, beats leave in the order they entered, with none dropped or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_data | input | LANES*DW | Input vector, lane 0 in the low bits |
| in_bias | input | LANES*DW | Per-lane bias |
| in_target | input | LANES*DW | Per-lane target for the loss stage |
| in_act | input | LANES*DW | Per-lane stored post-activation value |
| in_path | input | 4 | Pathway code: bit0 bias+rectifier, bit1 loss, bit2 derivative, bit3 ignored |
| in_leak | input | DW | Rectifier slope, Q8.8 |
| in_scale | input | DW | 2/N loss constant, Q8.8 |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take a beat |
| out_data | output | LANES*DW | Processed vector |

## Verification
Two functions can fall in the same cycle: a pathway change and a stall. A beat with a new pathway code can enter in the very cycle that back-pressure freezes older beats of a different code, and the frozen beats must keep their own settings while the new one waits. The stimulus table alternates codes on every beat. It is streamed three times: once at full rate, once with gaps on `in_valid` combined with periodic low `out_ready`, and once with the output stalled from the start. Every delivered beat is compared in order against its precomputed result. Directed tests also measure the fill count under a stall, the exact latency, and reset with beats in flight.

// File: rtl/vpp_pkg.sv
package vpp_pkg;
  localparam int unsigned PATH_W = 4;
  localparam int unsigned PB_FWD  = 0;
  localparam int unsigned PB_LOSS = 1;
  localparam int unsigned PB_DRV  = 2;

  typedef enum logic [1:0] {
    ST_BIAS  = 2'd0,
    ST_RELU  = 2'd1,
    ST_LOSS  = 2'd2,
    ST_DERIV = 2'd3
  } stage_e;
endpackage

// File: rtl/vpp_delay.sv
module vpp_delay #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] tap [DEPTH+1];
  assign tap[0] = d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)   tap[g+1] <= '0;
      else if (adv) tap[g+1] <= tap[g];
    end
  end

  assign q = tap[DEPTH];
endmodule

// File: rtl/vpp_stage.sv
module vpp_stage
  import vpp_pkg::*;
#(
  parameter int unsigned LANES = 2,
  parameter int unsigned DW    = 16,
  parameter int unsigned FRAC  = 8,
  parameter stage_e      KIND  = ST_BIAS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  logic                i_vld,
  input  logic                i_en,
  input  logic [LANES*DW-1:0] i_data,
  input  logic [LANES*DW-1:0] i_opnd,
  input  logic [DW-1:0]       i_coef,
  output logic                o_vld,
  output logic [LANES*DW-1:0] o_data
);
  localparam int unsigned PW = 2 * DW;

  function automatic logic [DW-1:0] qmul(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic signed [PW-1:0] p;
    p = $signed({{DW{a[DW-1]}}, a}) * $signed({{DW{b[DW-1]}}, b});
    return p[FRAC+DW-1:FRAC];
  endfunction

  logic [LANES*DW-1:0] res;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DW-1:0] x, op, y;
    assign x  = i_data[l*DW +: DW];
    assign op = i_opnd[l*DW +: DW];

    always_comb begin
      case (KIND)
        ST_BIAS:  y = x + op;
        ST_RELU:  y = x[DW-1] ? qmul(x, i_coef) : x;
        ST_LOSS:  y = qmul(x - op, i_coef);
        default:  y = ($signed(op) > 0) ? x : qmul(x, i_coef);
      endcase
    end

    assign res[l*DW +: DW] = i_en ? y : x;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_vld  <= 1'b0;
      o_data <= '0;
    end else if (adv) begin
      o_vld  <= i_vld;
      o_data <= res;
    end
  end
endmodule

// File: rtl/vec_postproc.sv
module vec_postproc
  import vpp_pkg::*;
#(
  parameter int unsigned LANES = 2,
  parameter int unsigned DW    = 16,
  parameter int unsigned FRAC  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES*DW-1:0] in_data,
  input  logic [LANES*DW-1:0] in_bias,
  input  logic [LANES*DW-1:0] in_target,
  input  logic [LANES*DW-1:0] in_act,
  input  logic [PATH_W-1:0]   in_path,
  input  logic [DW-1:0]       in_leak,
  input  logic [DW-1:0]       in_scale,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LANES*DW-1:0] out_data
);
  localparam int unsigned NST = 4;
  localparam int unsigned VW  = LANES * DW;
  localparam int unsigned CW  = PATH_W + 2 * DW;

  logic          adv;
  logic          vld_s  [NST+1];
  logic [VW-1:0] data_s [NST+1];
  logic [CW-1:0] ctl_s  [NST];
  logic [VW-1:0] tgt_al, act_al;

  assign adv      = !vld_s[NST] || out_ready;
  assign in_ready = adv;

  assign vld_s[0]  = in_valid;
  assign data_s[0] = in_data;
  assign ctl_s[0]  = {in_path, in_leak, in_scale};

  // per-beat control travels one register per stage
  for (genvar k = 1; k < NST; k++) begin : g_ctl
    vpp_delay #(.W(CW), .DEPTH(1)) ctl_dly_i (
      .clk(clk), .rst_n(rst_n), .adv(adv), .d(ctl_s[k-1]), .q(ctl_s[k])
    );
  end

  vpp_delay #(.W(VW), .DEPTH(int'(ST_LOSS))) tgt_dly_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .d(in_target), .q(tgt_al)
  );
  vpp_delay #(.W(VW), .DEPTH(int'(ST_DERIV))) act_dly_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .d(in_act), .q(act_al)
  );

  for (genvar k = 0; k < NST; k++) begin : g_st
    localparam stage_e KND = stage_e'(k);
    logic [PATH_W-1:0] pth;
    logic [DW-1:0]     lk, sc, coef;
    logic [VW-1:0]     opnd;
    logic              en;

    assign {pth, lk, sc} = ctl_s[k];

    always_comb begin
      case (KND)
        ST_BIAS:  begin en = pth[PB_FWD];  opnd = in_bias;      coef = lk; end
        ST_RELU:  begin en = pth[PB_FWD];  opnd = '0;           coef = lk; end
        ST_LOSS:  begin en = pth[PB_LOSS]; opnd = tgt_al;       coef = sc; end
        default:  begin en = pth[PB_DRV];  opnd = act_al;       coef = lk; end
      endcase
    end

    vpp_stage #(.LANES(LANES), .DW(DW), .FRAC(FRAC), .KIND(KND)) stage_i (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .i_vld (vld_s[k]),
      .i_en  (en),
      .i_data(data_s[k]),
      .i_opnd(opnd),
      .i_coef(coef),
      .o_vld (vld_s[k+1]),
      .o_data(data_s[k+1])
    );
  end

  assign out_valid = vld_s[NST];
  assign out_data  = data_s[NST];
endmodule

// File: rtl/vpp_chk.sv
module vpp_chk #(
  parameter int unsigned LANES = 2,
  parameter int unsigned DW    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [LANES*DW-1:0] out_data
);
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n)             since_rst <= '0;
    else if (since_rst < 7) since_rst <= since_rst + 3'd1;
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2
  backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd5 && $past(in_valid && in_ready, 4) &&
     $past(out_ready, 3) && $past(out_ready, 2) && $past(out_ready, 1)) |-> out_valid);
endmodule

bind vec_postproc vpp_chk #(.LANES(LANES), .DW(DW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/vec_postproc_tb_top.sv
module vec_postproc_tb_top;
  localparam int LANES = 2;
  localparam int DW    = 16;
  localparam int VW    = LANES * DW;
  localparam int NV    = 8;
  localparam int EW    = 4 + 2*DW + 5*VW;

  // {path, leak, scale, data, bias, target, act, expected}; lane 1 upper
  localparam logic [EW-1:0] VEC [NV] = '{
    {4'h1, 16'h00A0, 16'h0010, 32'hFE00_0100, 32'h0000_0080, 32'h0, 32'h0, 32'hFEC0_0180},
    {4'h0, 16'h00A0, 16'h0010, 32'hFF00_1234, 32'h0055_0066, 32'h0, 32'h0, 32'hFF00_1234},
    {4'h2, 16'h00A0, 16'h0010, 32'h0000_0300, 32'h0, 32'h0100_0100, 32'h0, 32'hFFF0_0020},
    {4'h4, 16'h0080, 16'h0010, 32'h0200_0200, 32'h0, 32'h0, 32'hFF00_0100, 32'h0100_0200},
    {4'h6, 16'h0040, 16'h0100, 32'h0100_0500, 32'h0, 32'h0300_0100, 32'h0010_0000, 32'hFE00_0100},
    {4'h9, 16'h00A0, 16'h0010, 32'hFFFF_0000, 32'h0, 32'h0, 32'h0, 32'hFFFF_0000},
    {4'h7, 16'h0080, 16'h0200, 32'h0040_0100, 32'h0040_FE00, 32'h0100_0000, 32'hFFFF_0100, 32'hFF80_FF00},
    {4'h1, 16'h00A0, 16'h0010, 32'h0000_7F00, 32'h0000_0200, 32'h0, 32'h0, 32'h0000_B0A0}
  };
  localparam string TAG [NV] = '{
    "R4 R6", "R10", "R7", "R8", "R7 R8 R11", "R10 R6", "R9 R11", "R5 R6"
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [VW-1:0] in_data = '0, in_bias = '0, in_target = '0, in_act = '0, out_data;
  logic [3:0] in_path = '0;
  logic [DW-1:0] in_leak = '0, in_scale = '0;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  vec_postproc #(.LANES(LANES), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_bias(in_bias), .in_target(in_target), .in_act(in_act),
    .in_path(in_path), .in_leak(in_leak), .in_scale(in_scale),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input int i);
    {in_path, in_leak, in_scale, in_data, in_bias, in_target, in_act} = VEC[i][EW-1:VW];
  endtask

  // mode 0 full rate, 1 gapped both sides, 2 output stalled first
  task automatic run_stream(input int mode);
    int sent = 0, got = 0, cyc = 0;
    logic [VW-1:0] held = '0;
    while (got < NV && cyc < 400) begin
      @(negedge clk);
      case (mode)
        0: begin out_ready = 1'b1; in_valid = (sent < NV); end
        1: begin out_ready = (cyc % 3 != 1); in_valid = (sent < NV) && (cyc % 4 != 2); end
        default: begin out_ready = (cyc >= 10); in_valid = (sent < NV); end
      endcase
      if (sent < NV) load(sent);
      #1;
      if (mode == 2 && cyc == 5) held = out_data;
      if (mode == 2 && cyc == 9) begin
        check("R2 fill count", VW'(sent), VW'(4));
        check("R2 in_ready low", VW'(in_ready), VW'(0));
        check("R2 output held", out_data, held);
      end
      if (out_valid && out_ready) begin
        check({TAG[got], " R12 mode"}, out_data, VEC[got][VW-1:0]);
        got++;
      end
      if (in_valid && in_ready) sent++;
      cyc++;
    end
    if (got != NV) check("R12 beats delivered", VW'(got), VW'(NV));
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 out_valid after reset", VW'(out_valid), VW'(0));
    check("R1 in_ready after reset", VW'(in_ready), VW'(1));

    run_stream(0);
    run_stream(1);
    run_stream(2);

    // R3 latency
    begin
      int n = 1;
      @(negedge clk);
      load(1);
      in_valid = 1'b1;
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      while (!out_valid && n < 10) begin
        @(negedge clk);
        n++;
      end
      check("R3 latency", VW'(n), VW'(4));
      check("R3 data", out_data, VEC[1][VW-1:0]);
    end

    // R1 reset with beats in flight
    repeat (3) @(negedge clk);
    out_ready = 1'b0;
    load(0);
    in_valid = 1'b1;
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    #1;
    check("R1 flush out_valid", VW'(out_valid), VW'(0));
    check("R1 flush in_ready", VW'(in_ready), VW'(1));
    repeat (5) @(negedge clk);
    check("R1 nothing emerges", VW'(out_valid), VW'(0));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule